// File: doc/BRIEF.md
# Flash Program Status Responder

This block stands in for the device side of a small flash store whose byte-program and sector-erase operations take time to complete. The host starts an operation through a one-cycle command port. While the operation is running, a read of the affected location returns a status byte instead of stored data. For a program, the affected location is the target byte. For an erase, it is any byte in the target sector. The host polls until the status stops changing, and then reads the stored byte back to confirm what was written.

The status byte carries two flags. The alternating flag (bit 6) inverts on every status read while the operation runs, and stops changing once the operation is over. The failure flag (bit 5) reports that the operation ran into its time-out. Programming can only clear bits: the stored byte becomes the bitwise AND of the old byte and the new one. A program that asks a bit stored as 0 to become 1 is illegal. Such a program is held busy until the time-out. It then stops with the failure flag set, and the stored array is left untouched. Reads of the failed byte keep returning the frozen status until the next accepted command. The busy time and the time-out are parameters counted in clock cycles.

Top module: `flash_status_resp`

## Requirements
- R1: After reset, `busy` is 0, `rd_data` is 0x00, and every byte of the array reads 0xFF.
- R2: A valid command accepted while idle raises `busy` on the next cycle. For a legal operation, `busy` stays high for exactly BUSY_CYC cycles (default 8).
- R3: While busy, a read of the affected location returns a status byte. Bit 6 of that byte starts at 0 after the command and inverts on each such read. Bits 7 and 4..0 are 0, and bit 5 is 0. Reads of other addresses return the stored data.
- R4: Once the operation has finished, two consecutive reads of the target return the same value, and that value is the stored byte.
- R5: A legal program stores the bitwise AND of the command data and the old byte.
- R6: An erase sets every byte of the sector to 0xFF, and no byte outside it changes. The sector is the address bits above the low SECT_LSB bits (default 4, so 16-byte sectors). While the erase runs, a read of any address in that sector returns status.
- R7: An illegal program holds `busy` for TMO_CYC cycles (default 24) and leaves the array unchanged. Afterwards, reads of the target return 0x20 or 0x60 with bit 6 no longer changing, and bit 5 reads 1.
- R8: Commands presented while `busy` is high are ignored.
- R9: The command code on `cmd_op` is 2'b01 for program and 2'b10 for erase. Codes 2'b00 and 2'b11 are ignored.
- R10: `rd_data` is updated one cycle after a cycle with `rd_en` high, and holds its value when `rd_en` is low.
- R11: A command accepted after a failure clears the failure status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 2 | 01 program, 10 erase |
| cmd_addr | input | ADDR_W (6) | Byte address of a program; any address in the sector for an erase |
| cmd_data | input | DATA_W (8) | Byte to program |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W (6) | Read address |
| rd_data | output | DATA_W (8) | Registered read result: data or status |
| busy | output | 1 | Operation in progress |

## Verification
A command sampled at a clock edge shows `busy` at the next falling edge. The bench counts the falling edges at which `busy` is high and expects BUSY_CYC for a legal operation and TMO_CYC for an illegal program. A read strobe driven at a falling edge yields `rd_data` at the following falling edge, one register later, and each read task samples exactly there. The array write happens on the same edge at which `busy` falls. Verification reads are therefore issued only after `busy` has been observed low.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PROG  = 2'd1,
    ST_ERASE = 2'd2,
    ST_FAIL  = 2'd3
  } fsr_state_e;

  localparam logic [1:0] OP_PROG  = 2'b01;
  localparam logic [1:0] OP_ERASE = 2'b10;
endpackage

// File: rtl/fsr_array.sv
module fsr_array #(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 8,
  parameter int SECT_LSB = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_prog,
  input  logic              wr_erase,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] a_addr,
  output logic [DATA_W-1:0] a_data,
  input  logic [ADDR_W-1:0] b_addr,
  output logic [DATA_W-1:0] b_data
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int SECT_W = ADDR_W - SECT_LSB;

  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    localparam logic [ADDR_W-1:0] IDX = ADDR_W'(g);
    logic              sel_p, sel_e, en;
    logic [DATA_W-1:0] nxt;

    always_comb begin
      sel_p = wr_prog && (wr_addr == IDX);
      sel_e = wr_erase && (wr_addr[ADDR_W-1:SECT_LSB] == IDX[ADDR_W-1:SECT_LSB]);
      en    = sel_p || sel_e;
      nxt   = sel_e ? {DATA_W{1'b1}} : (mem_q[g] & wr_data);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mem_q[g] <= {DATA_W{1'b1}};
      else if (en) mem_q[g] <= nxt;
    end
  end

  assign a_data = mem_q[a_addr];
  assign b_data = mem_q[b_addr];

  logic unused_w;
  assign unused_w = ^SECT_W;
endmodule

// File: rtl/fsr_seq.sv
module fsr_seq
  import flash_status_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 8,
  parameter int BUSY_CYC = 8,
  parameter int TMO_CYC  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic [DATA_W-1:0] cur_byte,
  output fsr_state_e        state,
  output logic [ADDR_W-1:0] op_addr,
  output logic              accept,
  output logic              busy,
  output logic              wr_prog,
  output logic              wr_erase,
  output logic [DATA_W-1:0] wr_data
);
  localparam int CNT_W = $clog2(TMO_CYC + 1);
  localparam logic [CNT_W-1:0] LIM_OK  = CNT_W'(BUSY_CYC - 1);
  localparam logic [CNT_W-1:0] LIM_TMO = CNT_W'(TMO_CYC - 1);

  fsr_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              ill_q, ill_d;
  logic [CNT_W-1:0]  limit;

  assign busy   = (state_q == ST_PROG) || (state_q == ST_ERASE);
  assign accept = cmd_valid && !busy && ((cmd_op == OP_PROG) || (cmd_op == OP_ERASE));
  assign limit  = ill_q ? LIM_TMO : LIM_OK;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    addr_d   = addr_q;
    data_d   = data_q;
    ill_d    = ill_q;
    wr_prog  = 1'b0;
    wr_erase = 1'b0;
    if (accept) begin
      state_d = (cmd_op == OP_PROG) ? ST_PROG : ST_ERASE;
      cnt_d   = '0;
      addr_d  = cmd_addr;
      data_d  = cmd_data;
      ill_d   = (cmd_op == OP_PROG) && (|(cmd_data & ~cur_byte));
    end else if (busy) begin
      if (cnt_q == limit) begin
        if (ill_q) begin
          state_d = ST_FAIL;
        end else begin
          state_d  = ST_IDLE;
          wr_prog  = (state_q == ST_PROG);
          wr_erase = (state_q == ST_ERASE);
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      ill_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (accept) begin
        addr_q <= addr_d;
        data_q <= data_d;
        ill_q  <= ill_d;
      end
    end
  end

  assign state   = state_q;
  assign op_addr = addr_q;
  assign wr_data = data_q;
endmodule

// File: rtl/fsr_status.sv
module fsr_status
  import flash_status_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 8,
  parameter int SECT_LSB = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fsr_state_e        state,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic              accept,
  input  logic              busy,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] arr_byte,
  output logic              stat_hit,
  output logic [DATA_W-1:0] rd_data
);
  logic              tog_q, tog_d, tog_en;
  logic [DATA_W-1:0] rd_q, rd_d, stat;

  always_comb begin
    unique case (state)
      ST_PROG, ST_FAIL: stat_hit = (rd_addr == op_addr);
      ST_ERASE:         stat_hit = (rd_addr[ADDR_W-1:SECT_LSB] == op_addr[ADDR_W-1:SECT_LSB]);
      default:          stat_hit = 1'b0;
    endcase
    stat    = '0;
    stat[6] = tog_q;
    stat[5] = (state == ST_FAIL);
    rd_d    = stat_hit ? stat : arr_byte;
    tog_en  = accept || (rd_en && stat_hit && busy);
    tog_d   = accept ? 1'b0 : ~tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q <= 1'b0;
      rd_q  <= '0;
    end else begin
      if (tog_en) tog_q <= tog_d;
      if (rd_en)  rd_q  <= rd_d;
    end
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/flash_status_resp.sv
module flash_status_resp
  import flash_status_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 8,
  parameter int SECT_LSB = 4,
  parameter int BUSY_CYC = 8,
  parameter int TMO_CYC  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy
);
  fsr_state_e        state;
  logic [ADDR_W-1:0] op_addr;
  logic              accept, wr_prog, wr_erase, stat_hit;
  logic [DATA_W-1:0] wr_data, cur_byte, arr_byte;

  fsr_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUSY_CYC(BUSY_CYC), .TMO_CYC(TMO_CYC)
  ) i_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cur_byte(cur_byte),
    .state(state), .op_addr(op_addr), .accept(accept), .busy(busy),
    .wr_prog(wr_prog), .wr_erase(wr_erase), .wr_data(wr_data)
  );

  fsr_array #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_LSB(SECT_LSB)
  ) i_array (
    .clk(clk), .rst_n(rst_n), .wr_prog(wr_prog), .wr_erase(wr_erase),
    .wr_addr(op_addr), .wr_data(wr_data),
    .a_addr(cmd_addr), .a_data(cur_byte),
    .b_addr(rd_addr), .b_data(arr_byte)
  );

  fsr_status #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_LSB(SECT_LSB)
  ) i_status (
    .clk(clk), .rst_n(rst_n), .state(state), .op_addr(op_addr),
    .accept(accept), .busy(busy), .rd_en(rd_en), .rd_addr(rd_addr),
    .arr_byte(arr_byte), .stat_hit(stat_hit), .rd_data(rd_data)
  );
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker #(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 8,
  parameter int TMO_CYC = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [1:0]        cmd_op,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              busy,
  input logic              stat_hit,
  input logic [ADDR_W-1:0] op_addr
);
  int run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= 0;
    else if (busy) run_q <= run_q + 1;
    else           run_q <= 0;
  end

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid && (cmd_op == 2'b01 || cmd_op == 2'b10)) |=> busy);

  // R9
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid && (cmd_op == 2'b00 || cmd_op == 2'b11)) |=> !busy);

  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> $stable(op_addr));

  // R3
  stat_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy && stat_hit) |=> (rd_data[7] == 1'b0 && rd_data[5:0] == '0));

  // R7
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= TMO_CYC);

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

bind flash_status_resp fsr_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TMO_CYC(TMO_CYC)
) i_fsr_checker (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .rd_en(rd_en), .rd_data(rd_data), .busy(busy), .stat_hit(stat_hit),
  .op_addr(op_addr)
);

// File: tb/test_flash_status_resp.sv
module test_flash_status_resp;
  localparam int BUSY_CYC = 8;
  localparam int TMO_CYC  = 24;

  logic       clk, rst_n, cmd_valid, rd_en, busy;
  logic [1:0] cmd_op;
  logic [5:0] cmd_addr, rd_addr;
  logic [7:0] cmd_data, rd_data;
  int checks, errors;

  flash_status_resp #(.BUSY_CYC(BUSY_CYC), .TMO_CYC(TMO_CYC)) i_flash_status_resp (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [1:0] op, input logic [5:0] a, input logic [7:0] d);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 busy", busy, 0);
    chk("R1 rd_data", rd_data, 8'h00);
    rd(6'd0, d);  chk("R1 byte0", d, 8'hFF);
    rd(6'd63, d); chk("R1 byte63", d, 8'hFF);
  endtask

  task automatic t_program();
    logic [7:0] d; int n;
    cmd(2'b01, 6'd5, 8'h5A);
    chk("R2 busy rise", busy, 1);
    wait_idle(n);
    chk("R2 busy length", n, BUSY_CYC);
    rd(6'd5, d); chk("R4 first read", d, 8'h5A);
    rd(6'd5, d); chk("R4 second read", d, 8'h5A);
  endtask

  task automatic t_toggle();
    logic [7:0] d; int n;
    cmd(2'b01, 6'd5, 8'h0A);
    rd(6'd5, d); chk("R3 status 1", d, 8'h00);
    rd(6'd5, d); chk("R3 status 2", d, 8'h40);
    rd(6'd6, d); chk("R3 other addr", d, 8'hFF);
    rd(6'd5, d); chk("R3 status 3", d, 8'h00);
    wait_idle(n);
    rd(6'd5, d); chk("R5 and result", d, 8'h0A);
    rd(6'd5, d); chk("R4 stable", d, 8'h0A);
  endtask

  task automatic t_erase();
    logic [7:0] d; int n;
    cmd(2'b01, 6'd20, 8'h33);
    wait_idle(n);
    cmd(2'b10, 6'd3, 8'h00);
    rd(6'd12, d); chk("R6 sector status 1", d, 8'h00);
    rd(6'd0, d);  chk("R6 sector status 2", d, 8'h40);
    rd(6'd20, d); chk("R6 outside data", d, 8'h33);
    wait_idle(n);
    rd(6'd5, d);  chk("R6 erased", d, 8'hFF);
    rd(6'd20, d); chk("R6 other sector kept", d, 8'h33);
  endtask

  task automatic t_ignore();
    logic [7:0] d; int n;
    cmd(2'b01, 6'd40, 8'h77);
    cmd(2'b10, 6'd40, 8'h00);
    cmd(2'b01, 6'd41, 8'h00);
    wait_idle(n);
    chk("R8 length unchanged", n + 2, BUSY_CYC);
    rd(6'd40, d); chk("R8 not erased", d, 8'h77);
    rd(6'd41, d); chk("R8 not programmed", d, 8'hFF);
    chk("R8 idle", busy, 0);
  endtask

  task automatic t_badop();
    logic [7:0] d;
    cmd(2'b00, 6'd40, 8'h00);
    chk("R9 op00 ignored", busy, 0);
    cmd(2'b11, 6'd40, 8'h00);
    chk("R9 op11 ignored", busy, 0);
    rd(6'd40, d); chk("R9 data kept", d, 8'h77);
  endtask

  task automatic t_fail();
    logic [7:0] d; int n;
    cmd(2'b01, 6'd40, 8'h88);
    wait_idle(n);
    chk("R7 timeout length", n, TMO_CYC);
    rd(6'd40, d); chk("R7 fail status 1", d, 8'h20);
    rd(6'd40, d); chk("R7 fail status 2", d, 8'h20);
    rd(6'd41, d); chk("R7 other addr", d, 8'hFF);
    @(negedge clk);
    chk("R10 hold", rd_data, 8'hFF);
    cmd(2'b10, 6'd33, 8'h00);
    wait_idle(n);
    rd(6'd40, d); chk("R11 cleared", d, 8'hFF);
    rd(6'd40, d); chk("R11 stable", d, 8'hFF);
  endtask

  task automatic t_fail_keep();
    logic [7:0] d; int n;
    cmd(2'b01, 6'd40, 8'h0F);
    wait_idle(n);
    cmd(2'b01, 6'd40, 8'hF0);
    wait_idle(n);
    chk("R7 length again", n, TMO_CYC);
    cmd(2'b10, 6'd0, 8'h00);
    wait_idle(n);
    rd(6'd40, d); chk("R7 array untouched", d, 8'h0F);
  endtask

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'b00; cmd_addr = '0;
    cmd_data = '0; rd_en = 1'b0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_toggle();
    t_erase();
    t_ignore();
    t_badop();
    t_fail();
    t_fail_keep();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule